// File: doc/BRIEF.md
# Dual-Lane Receive Deskew and Frame Merger

A receive frame on this link is split byte by byte across two lanes: lane A carries frame bytes 0, 2, 4 and so on, lane B carries bytes 1, 3, 5 and so on. Each lane runs at half the merged byte rate. Each lane delimits its share of the frame on its own, so the two lanes can start and end at different times because the cable pairs differ in delay. This block accepts the byte strobes of both lane framers and holds the lane that starts first in a small buffer. Once both lanes have started, it rebuilds the frame on a single byte-wide receive interface at up to one byte per cycle.

Output order is always an A byte, then a B byte, whatever order the lanes arrived in. The frame ends when both lanes have signalled their end and both buffers are empty. The valid window therefore follows the combined length of the frame. A frame in which A has exactly one byte more than B is legal and ends on an A byte. Any other length imbalance flags the last byte as errored. If one lane fills its buffer while the other has not started, the frame is thrown away and an error pulse is raised.

Top module: `frame_merge`

## Requirements
- R1: `rx_dv` stays low until both lanes have started, meaning each lane has delivered its first byte or has ended with no bytes. A byte taken in on one edge can appear on `rx_d` two edges later at the earliest.
- R2: A lane that starts early has up to DEPTH (8) bytes held without loss. A buffer holding exactly 8 bytes is not an overflow.
- R3: Output bytes follow frame order A0, B0, A1, B1, and so on, both when lane A starts first and when lane B starts first.
- R4: The block issues at most one output byte per cycle. When both buffers hold data, an A byte and the following B byte leave on consecutive cycles.
- R5: When the two lanes carry the same number of bytes, `rx_dv` drops after the last B byte and `rx_er` stays low.
- R6: When lane A carries exactly one byte more than lane B (B may carry zero), the final output byte is the last A byte and `rx_er` stays low.
- R7: When lane B carries more bytes than lane A, all surplus B bytes are output in order after the interleaved part. `rx_er` is high together with `rx_dv` on the final byte only.
- R8: When lane A carries two or more bytes more than lane B, all surplus A bytes are output in order. `rx_er` is high on the final byte only.
- R9: A byte arriving at a lane whose buffer already holds 8 bytes causes one cycle of `rx_er` high with `rx_dv` low. No byte of that frame is output. Lane input is then ignored until both lanes have ended, after which the next frame is merged normally.
- R10: While reset is high and after it is released, `rx_dv`, `rx_er` and `rx_d` are all zero.
- R11: A byte strobed on a lane after that lane's end pulse, within the same frame, is dropped and never reaches `rx_d`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Merged byte clock |
| rst | input | 1 | Synchronous reset, active high |
| a_vld | input | 1 | Lane A byte strobe |
| a_dat | input | 8 | Lane A byte |
| a_end | input | 1 | Lane A end-of-share pulse, carries no byte |
| b_vld | input | 1 | Lane B byte strobe |
| b_dat | input | 8 | Lane B byte |
| b_end | input | 1 | Lane B end-of-share pulse, carries no byte |
| rx_dv | output | 1 | Merged byte valid |
| rx_d | output | 8 | Merged byte, zero when not valid |
| rx_er | output | 1 | Error: final byte of an unbalanced frame, or a dropped-frame pulse with `rx_dv` low |

## Verification
Two functions can fall in the same cycle: a lane buffer taking in a byte, and the merger popping that same buffer or the other one. In skewed frames the late lane's first byte lands while the early lane's full backlog is being read out. One frame fills the early buffer to exactly eight entries, so a push and a pop meet at its depth boundary. The result is judged at the ports. The merged byte sequence, the error flag on each byte and the cycle spacing of the first A/B pair are each compared with values the bench derives from the two lane lengths alone.

// File: rtl/dsk_pkg.sv
`timescale 1ns/1ps
package dsk_pkg;
    localparam int BYTE_W     = 8;
    localparam int LANE_DEPTH = 8;

    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_MERGE = 2'd1,
        ST_DRAIN = 2'd2,
        ST_DROP  = 2'd3
    } mrg_state_e;

    typedef enum logic {
        LANE_A = 1'b0,
        LANE_B = 1'b1
    } lane_e;

    typedef struct packed {
        logic started;
        logic ended;
    } lane_flags_t;

    function automatic logic lane_ready(lane_flags_t f);
        return f.started | f.ended;
    endfunction

    function automatic lane_e other_lane(lane_e l);
        return (l == LANE_A) ? LANE_B : LANE_A;
    endfunction
endpackage

// File: rtl/lane_buf.sv
`timescale 1ns/1ps
module lane_buf #(
    parameter int DW    = 8,
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic [CW-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] step_ptr(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign do_push = push && (cnt_q != CW'(DEPTH));
    assign do_pop  = pop && (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= step_ptr(wp_q);
            if (do_pop)  rp_q <= step_ptr(rp_q);
            cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
        end
    end

    assign dout  = mem[rp_q];
    assign count = cnt_q;
endmodule

// File: rtl/merge_ctrl.sv
`timescale 1ns/1ps
module merge_ctrl
    import dsk_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          a_vld,
    input  logic          a_end,
    input  logic          b_vld,
    input  logic          b_end,
    input  logic [CW-1:0] cnt_a,
    input  logic [CW-1:0] cnt_b,
    output logic          acc_a,
    output logic          acc_b,
    output logic          pop_a,
    output logic          pop_b,
    output logic          flush,
    output logic          out_dv,
    output logic          out_er,
    output logic          ovf,
    output mrg_state_e    state
);
    mrg_state_e  st_q, st_d;
    lane_e       turn_q, turn_d, drn_q, drn_d;
    lane_flags_t fa_q, fb_q;
    logic        clr;

    logic [CW-1:0] cur_cnt, oth_cnt, src_cnt;
    logic          cur_end, oth_end, src_end;

    assign acc_a = a_vld && !fa_q.ended && (st_q != ST_DROP);
    assign acc_b = b_vld && !fb_q.ended && (st_q != ST_DROP);
    assign ovf   = (st_q != ST_DROP) &&
                   ((acc_a && cnt_a == CW'(DEPTH)) || (acc_b && cnt_b == CW'(DEPTH)));

    assign cur_cnt = (turn_q == LANE_A) ? cnt_a : cnt_b;
    assign cur_end = (turn_q == LANE_A) ? fa_q.ended : fb_q.ended;
    assign oth_cnt = (turn_q == LANE_A) ? cnt_b : cnt_a;
    assign oth_end = (turn_q == LANE_A) ? fb_q.ended : fa_q.ended;
    assign src_cnt = (drn_q == LANE_A) ? cnt_a : cnt_b;
    assign src_end = (drn_q == LANE_A) ? fa_q.ended : fb_q.ended;

    always_comb begin
        st_d   = st_q;
        turn_d = turn_q;
        drn_d  = drn_q;
        pop_a  = 1'b0;
        pop_b  = 1'b0;
        out_dv = 1'b0;
        out_er = 1'b0;
        flush  = 1'b0;
        clr    = 1'b0;
        case (st_q)
            ST_HUNT: begin
                if (lane_ready(fa_q) && lane_ready(fb_q)) st_d = ST_MERGE;
            end
            ST_MERGE: begin
                if (cur_cnt != '0) begin
                    pop_a  = (turn_q == LANE_A);
                    pop_b  = (turn_q == LANE_B);
                    out_dv = 1'b1;
                    turn_d = other_lane(turn_q);
                end else if (cur_end) begin
                    if (oth_cnt != '0) begin
                        st_d  = ST_DRAIN;
                        drn_d = other_lane(turn_q);
                    end else if (oth_end) begin
                        st_d = ST_HUNT;
                        clr  = 1'b1;
                    end
                end
            end
            ST_DRAIN: begin
                if (src_cnt >= CW'(2) || (src_cnt == CW'(1) && src_end)) begin
                    pop_a  = (drn_q == LANE_A);
                    pop_b  = (drn_q == LANE_B);
                    out_dv = 1'b1;
                    if (src_cnt == CW'(1)) begin
                        out_er = 1'b1;
                        st_d   = ST_HUNT;
                        clr    = 1'b1;
                    end
                end
            end
            ST_DROP: begin
                if (fa_q.ended && fb_q.ended) begin
                    st_d = ST_HUNT;
                    clr  = 1'b1;
                end
            end
            default: st_d = ST_HUNT;
        endcase
        if (ovf) begin
            st_d   = ST_DROP;
            flush  = 1'b1;
            clr    = 1'b0;
            pop_a  = 1'b0;
            pop_b  = 1'b0;
            out_dv = 1'b0;
            out_er = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= ST_HUNT;
            turn_q <= LANE_A;
            drn_q  <= LANE_A;
            fa_q   <= '0;
            fb_q   <= '0;
        end else begin
            st_q   <= st_d;
            drn_q  <= drn_d;
            turn_q <= clr ? LANE_A : turn_d;
            if (clr) begin
                fa_q <= '0;
                fb_q <= '0;
            end else begin
                fa_q.started <= fa_q.started | acc_a;
                fa_q.ended   <= fa_q.ended | a_end;
                fb_q.started <= fb_q.started | acc_b;
                fb_q.ended   <= fb_q.ended | b_end;
            end
        end
    end

    assign state = st_q;
endmodule

// File: rtl/frame_merge.sv
`timescale 1ns/1ps
module frame_merge
    import dsk_pkg::*;
#(
    parameter int DW    = BYTE_W,
    parameter int DEPTH = LANE_DEPTH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          a_vld,
    input  logic [DW-1:0] a_dat,
    input  logic          a_end,
    input  logic          b_vld,
    input  logic [DW-1:0] b_dat,
    input  logic          b_end,
    output logic          rx_dv,
    output logic [DW-1:0] rx_d,
    output logic          rx_er
);
    localparam int CW    = $clog2(DEPTH + 1);
    localparam int LANES = 2;

    logic          acc_a, acc_b, pop_a, pop_b, flush, out_dv, out_er, ovf;
    logic [CW-1:0] cnt_a, cnt_b;
    mrg_state_e    st;

    logic          lane_push [LANES];
    logic          lane_pop  [LANES];
    logic [DW-1:0] lane_din  [LANES];
    logic [DW-1:0] lane_dout [LANES];
    logic [CW-1:0] lane_cnt  [LANES];

    assign lane_push[0] = acc_a;
    assign lane_push[1] = acc_b;
    assign lane_din[0]  = a_dat;
    assign lane_din[1]  = b_dat;
    assign lane_pop[0]  = pop_a;
    assign lane_pop[1]  = pop_b;
    assign cnt_a        = lane_cnt[0];
    assign cnt_b        = lane_cnt[1];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        lane_buf #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_buf (
            .clk   (clk),
            .rst   (rst),
            .flush (flush),
            .push  (lane_push[g]),
            .din   (lane_din[g]),
            .pop   (lane_pop[g]),
            .dout  (lane_dout[g]),
            .count (lane_cnt[g])
        );
    end

    merge_ctrl #(.DEPTH(DEPTH), .CW(CW)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .a_vld  (a_vld),
        .a_end  (a_end),
        .b_vld  (b_vld),
        .b_end  (b_end),
        .cnt_a  (cnt_a),
        .cnt_b  (cnt_b),
        .acc_a  (acc_a),
        .acc_b  (acc_b),
        .pop_a  (pop_a),
        .pop_b  (pop_b),
        .flush  (flush),
        .out_dv (out_dv),
        .out_er (out_er),
        .ovf    (ovf),
        .state  (st)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_dv <= 1'b0;
            rx_er <= 1'b0;
            rx_d  <= '0;
        end else begin
            rx_dv <= out_dv;
            rx_er <= out_er;
            rx_d  <= pop_a ? lane_dout[0] : (pop_b ? lane_dout[1] : '0);
        end
    end
endmodule

// File: rtl/frame_merge_chk.sv
`timescale 1ns/1ps
module frame_merge_chk
    import dsk_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input mrg_state_e    st,
    input logic          pop_a,
    input logic          pop_b,
    input logic [CW-1:0] cnt_a,
    input logic [CW-1:0] cnt_b,
    input logic          ovf,
    input logic          rx_dv,
    input logic          rx_er
);
    AST_HUNT_SILENT: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HUNT) |=> !rx_dv); // R1

    AST_POP_HAS_DATA: assert property (@(posedge clk) disable iff (rst)
        (pop_a |-> cnt_a != '0) and (pop_b |-> cnt_b != '0)); // R2

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (cnt_a <= CW'(DEPTH)) && (cnt_b <= CW'(DEPTH))); // R2

    AST_ALT_ORDER: assert property (@(posedge clk) disable iff (rst)
        (st == ST_MERGE && pop_a) |=> !pop_a); // R3

    AST_SINGLE_POP: assert property (@(posedge clk) disable iff (rst)
        !(pop_a && pop_b)); // R4

    AST_ERR_LAST: assert property (@(posedge clk) disable iff (rst)
        (rx_dv && rx_er) |=> !rx_dv); // R7

    AST_OVF_PULSE: assert property (@(posedge clk) disable iff (rst)
        ovf |=> (rx_er && !rx_dv)); // R9
endmodule

bind frame_merge frame_merge_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .st    (st),
    .pop_a (pop_a),
    .pop_b (pop_b),
    .cnt_a (cnt_a),
    .cnt_b (cnt_b),
    .ovf   (ovf),
    .rx_dv (rx_dv),
    .rx_er (rx_er)
);

// File: tb/sim_frame_merge.sv
`timescale 1ns/1ps
module sim_frame_merge;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       a_vld = 1'b0, a_end = 1'b0, b_vld = 1'b0, b_end = 1'b0;
    logic [7:0] a_dat = '0, b_dat = '0;
    logic       rx_dv, rx_er;
    logic [7:0] rx_d;

    frame_merge u0 (
        .clk(clk), .rst(rst),
        .a_vld(a_vld), .a_dat(a_dat), .a_end(a_end),
        .b_vld(b_vld), .b_dat(b_dat), .b_end(b_end),
        .rx_dv(rx_dv), .rx_d(rx_d), .rx_er(rx_er)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // output monitor, sole writer of the capture arrays
    int got_d [256];
    bit got_e [256];
    int got_c [256];
    int got_n = 0;
    int er_only = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (rx_dv) begin
                if (got_n < 256) begin
                    got_d[got_n] = int'(rx_d);
                    got_e[got_n] = rx_er;
                    got_c[got_n] = cyc;
                end
                got_n++;
            end else if (rx_er) begin
                er_only++;
            end
        end
    end

    int lane_first [2];

    // la, lb, delay A, delay B, extra A byte after end, requirement number
    localparam int NV = 9;
    localparam int VEC [NV][6] = '{
        '{4, 4, 0, 0,  0, 5},   // R5 equal lengths, lanes in step
        '{4, 4, 0, 6,  0, 3},   // R3 lane A starts first
        '{4, 4, 7, 0,  0, 3},   // R3 lane B starts first
        '{5, 4, 0, 3,  0, 6},   // R6 A one byte longer
        '{3, 5, 2, 0,  0, 7},   // R7 B longer
        '{6, 3, 0, 0,  0, 8},   // R8 A three bytes longer
        '{3, 3, 0, 4,  1, 11},  // R11 stray A byte after its end
        '{1, 0, 0, 0,  0, 6},   // R6 single byte, B empty
        '{8, 8, 0, 18, 0, 2}    // R2 A buffer exactly full
    };

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic lane_send(input bit lb, input int dly, input int n,
                             input int base, input bit extra);
        step();
        repeat (dly) step();
        for (int i = 0; i < n; i++) begin
            if (i == 0) lane_first[lb] = cyc;
            if (lb) begin b_vld = 1'b1; b_dat = 8'(base + 2*i + 1); end
            else    begin a_vld = 1'b1; a_dat = 8'(base + 2*i); end
            step();
            if (lb) b_vld = 1'b0; else a_vld = 1'b0;
            step();
        end
        if (lb) b_end = 1'b1; else a_end = 1'b1;
        step();
        if (lb) b_end = 1'b0; else a_end = 1'b0;
        if (extra) begin
            if (lb) begin b_vld = 1'b1; b_dat = 8'hEE; end
            else    begin a_vld = 1'b1; a_dat = 8'hEE; end
            step();
            if (lb) b_vld = 1'b0; else a_vld = 1'b0;
        end
    endtask

    task automatic run_frame(input int la, input int lb, input int da, input int db,
                             input bit ext, input string tag, input int base,
                             output int s0);
        int exp_d [32];
        int exp_n = 0;
        int mn = (la < lb) ? la : lb;
        bit last_er = (lb > la) || (la > lb + 1);
        int bad_i, bad_er, e0;
        for (int i = 0; i < mn; i++) begin
            exp_d[exp_n++] = base + 2*i;
            exp_d[exp_n++] = base + 2*i + 1;
        end
        for (int i = mn; i < la; i++) exp_d[exp_n++] = base + 2*i;
        for (int i = mn; i < lb; i++) exp_d[exp_n++] = base + 2*i + 1;
        s0 = got_n;
        e0 = er_only;
        fork
            lane_send(1'b0, da, la, base, ext);
            lane_send(1'b1, db, lb, base, 1'b0);
        join
        repeat (30) step();
        chk(got_n - s0 == exp_n, tag, "byte count", got_n - s0, exp_n);
        bad_i = -1;
        for (int k = 0; k < exp_n && k < got_n - s0; k++)
            if (bad_i < 0 && got_d[s0 + k] != exp_d[k]) bad_i = k;
        if (bad_i < 0) chk(1'b1, tag, "byte value", 0, 0);
        else chk(1'b0, tag, "byte value", got_d[s0 + bad_i], exp_d[bad_i]);
        bad_er = 0;
        for (int k = 0; k < got_n - s0; k++)
            if (got_e[s0 + k] != ((k == exp_n - 1) && last_er)) bad_er++;
        chk(bad_er == 0, tag, "errored bytes misflagged", bad_er, 0);
        chk(er_only == e0, tag, "error pulses without data", er_only - e0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            chk(1'b0, "watchdog", "run finished", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int s0, late, e0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 outputs held at zero during reset
        chk(!rx_dv && !rx_er && rx_d == 8'h00, "R10", "outputs in reset",
            int'({rx_dv, rx_er}), 0);
        @(posedge clk); #1;
        rst = 1'b0;
        repeat (2) step();
        @(negedge clk);
        chk(!rx_dv && !rx_er && rx_d == 8'h00, "R10", "outputs after reset",
            int'({rx_dv, rx_er}), 0);

        for (int v = 0; v < NV; v++) begin
            string tag = $sformatf("R%0d", VEC[v][5]);
            run_frame(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4] != 0,
                      tag, v * 24, s0);
            // R1 first output only after the later lane delivered its first byte
            if (VEC[v][2] != VEC[v][3] && VEC[v][1] > 0) begin
                late = (lane_first[0] > lane_first[1]) ? lane_first[0] : lane_first[1];
                chk(got_n > s0 && got_c[s0] >= late + 2, "R1", "first output cycle",
                    got_c[s0] - late, 2);
            end
            // R4 a buffered A byte and its B partner leave on consecutive cycles
            if (v == 1 || v == 8)
                chk(got_n > s0 + 1 && got_c[s0 + 1] == got_c[s0] + 1, "R4",
                    "A/B pair spacing", got_c[s0 + 1] - got_c[s0], 1);
        end

        // R9 lane A overflows while lane B has not started
        s0 = got_n;
        e0 = er_only;
        fork
            lane_send(1'b0, 0, 9, 200, 1'b0);
            lane_send(1'b1, 40, 3, 200, 1'b0);
        join
        repeat (30) step();
        chk(got_n == s0, "R9", "bytes output from dropped frame", got_n - s0, 0);
        chk(er_only - e0 == 1, "R9", "error pulses on overflow", er_only - e0, 1);
        // R9 next frame merges normally after the drop
        run_frame(2, 2, 0, 1, 1'b0, "R9", 100, s0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule